// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the translation path of a memory management unit. It takes a 32-bit virtual address together with an access kind: load, store or instruction fetch. It then walks a two-level page table held in memory and returns either a physical address or a fault. The walk starts from a base register. The upper ten bits of the virtual address pick a directory entry. That entry names the page holding the second-level table. The next ten bits pick the entry in that table. The low twelve bits are the offset within a 4 KB page and pass through unchanged.

Both tables are read over one simple memory port. The port holds a request until the memory acknowledges it. The same port writes a table entry back once, to set its dirty bit, when a permitted store hits a clean page. Only one walk runs at a time. Writing the base register switches the active address space, as on a context switch, for every walk accepted afterwards.

Entry layout, used by both levels: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 dirty, bits 31:12 page frame number. A directory entry uses only the valid bit and the frame field.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: A successful walk returns `rsp_pa` = {frame field of the second-level entry, `va[11:0]`} with `rsp_fault` = 0.
- R3: The first memory read is at base + 4·`va[31:22]`. The second is at {directory frame, 12'h000} + 4·`va[21:12]`. A request keeps its address and direction until `mem_ack`.
- R4: A directory entry with valid = 0 ends the walk with a not-present fault after exactly one memory access.
- R5: A second-level entry with valid = 0 gives a not-present fault after exactly two memory accesses.
- R6: A load needs the read bit, a store the write bit and a fetch the execute bit (`req_acc` 0 = load, 1 = store, 2 = fetch). Code 3 is always refused. A refused access gives a permission fault.
- R7: `rsp_kind` is 0 for not-present and 1 for permission violation, and `rsp_va` carries the virtual address of the walk.
- R8: A permitted store to an entry whose dirty bit is 0 writes that entry back, with bit 4 set, to its own address before responding. If the dirty bit is already 1, no write is made.
- R9: A write to the base register changes the directory used by every later walk.
- R10: `req_ready` is low from the cycle after a request is accepted until the cycle after the one-cycle `rsp_valid` pulse.
- R11: A walk that faults, or a load or fetch, makes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New table base address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_kind | output | 1 | Fault kind: 0 not present, 1 permission |
| rsp_pa | output | 32 | Physical address |
| rsp_va | output | 32 | Virtual address of the walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Entry written back |
| mem_ack | input | 1 | Memory access done |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench builds the walker with its default split of 10/10/12 bits and 32-bit entries. It places two small address spaces in a 16 KB memory model, and each space has its own directory and table. All 16 second-level entries of the first table are set up so that each combination of valid, read, write and execute occurs. Every one of them is walked with all four access codes. This covers every permission outcome, the dirty write-back and the fault kinds, and the bench compares the exact access addresses and counts. Invalid directory slots and a switch of the base register between the two spaces cover the early exit and the address space change.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_D = 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_TBL, ST_MARK, ST_DONE
  } walk_st_e;

  localparam logic KIND_ABSENT = 1'b0;
  localparam logic KIND_PERM   = 1'b1;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       can_r,
  input  logic       can_w,
  input  logic       can_x,
  output logic       allowed
);
  always_comb begin
    unique case (acc)
      ACC_LOAD:  allowed = can_r;
      ACC_STORE: allowed = can_w;
      ACC_FETCH: allowed = can_x;
      default:   allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int ENT_W = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_kind,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [VA_W-1:0]  rsp_va,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata
);
  localparam int FRM_W = PA_W - OFF_W;
  localparam int DPAD  = PA_W - DIR_W - 2;
  localparam int TPAD  = PA_W - TBL_W - 2;

  walk_st_e         st_q, st_n;
  logic [VA_W-1:0]  va_q, va_n;
  logic [1:0]       acc_q, acc_n;
  logic [PA_W-1:0]  addr_q, addr_n;
  logic [ENT_W-1:0] ent_q, ent_n;
  logic [PA_W-1:0]  pa_q, pa_n;
  logic             flt_q, flt_n;
  logic             kind_q, kind_n;
  logic             allowed;

  ptw_perm_check u_perm (
    .acc     (acc_q),
    .can_r   (mem_rdata[BIT_R]),
    .can_w   (mem_rdata[BIT_W]),
    .can_x   (mem_rdata[BIT_X]),
    .allowed (allowed)
  );

  always_comb begin
    st_n   = st_q;
    va_n   = va_q;
    acc_n  = acc_q;
    addr_n = addr_q;
    ent_n  = ent_q;
    pa_n   = pa_q;
    flt_n  = flt_q;
    kind_n = kind_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        va_n   = req_va;
        acc_n  = req_acc;
        flt_n  = 1'b0;
        addr_n = base + {{DPAD{1'b0}}, req_va[VA_W-1 -: DIR_W], 2'b00};
        st_n   = ST_DIR;
      end
      ST_DIR: if (mem_ack) begin
        if (!mem_rdata[BIT_V]) begin
          flt_n  = 1'b1;
          kind_n = KIND_ABSENT;
          st_n   = ST_DONE;
        end else begin
          addr_n = {mem_rdata[ENT_W-1 -: FRM_W], {OFF_W{1'b0}}}
                 + {{TPAD{1'b0}}, va_q[OFF_W +: TBL_W], 2'b00};
          st_n   = ST_TBL;
        end
      end
      ST_TBL: if (mem_ack) begin
        ent_n = mem_rdata;
        if (!mem_rdata[BIT_V]) begin
          flt_n  = 1'b1;
          kind_n = KIND_ABSENT;
          st_n   = ST_DONE;
        end else if (!allowed) begin
          flt_n  = 1'b1;
          kind_n = KIND_PERM;
          st_n   = ST_DONE;
        end else begin
          pa_n = {mem_rdata[ENT_W-1 -: FRM_W], va_q[OFF_W-1:0]};
          st_n = (acc_q == ACC_STORE && !mem_rdata[BIT_D]) ? ST_MARK : ST_DONE;
        end
      end
      ST_MARK: if (mem_ack) st_n = ST_DONE;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      acc_q  <= '0;
      addr_q <= '0;
      ent_q  <= '0;
      pa_q   <= '0;
      flt_q  <= 1'b0;
      kind_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      va_q   <= va_n;
      acc_q  <= acc_n;
      addr_q <= addr_n;
      ent_q  <= ent_n;
      pa_q   <= pa_n;
      flt_q  <= flt_n;
      kind_q <= kind_n;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_fault = flt_q;
  assign rsp_kind  = kind_q;
  assign rsp_pa    = pa_q;
  assign rsp_va    = va_q;
  assign mem_req   = (st_q == ST_DIR) || (st_q == ST_TBL) || (st_q == ST_MARK);
  assign mem_we    = (st_q == ST_MARK);
  assign mem_addr  = addr_q;
  assign mem_wdata = ent_q | (ENT_W'(1) << BIT_D);
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int ENT_W = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_kind,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [VA_W-1:0]  rsp_va,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata
);
  logic [1:0]      rst_sync;
  logic            rst_n_i;
  logic [PA_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  ptw_base_reg #(.W(PA_W)) u_base (
    .clk (clk), .rst_n (rst_n_i), .we (base_we), .d (base_wdata), .q (base)
  );

  ptw_walk_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W),
    .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .base      (base),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_va    (req_va),
    .req_acc   (req_acc),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_kind  (rsp_kind),
    .rsp_pa    (rsp_pa),
    .rsp_va    (rsp_va),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int ENT_W = 32,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic [1:0]       req_acc,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [VA_W-1:0]  rsp_va,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PA_W-1:0]  mem_addr,
  input logic [ENT_W-1:0] mem_wdata,
  input logic             mem_ack
);
  logic [VA_W-1:0] va_seen;
  logic [1:0]      acc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_seen  <= '0;
      acc_seen <= '0;
    end else if (req_valid && req_ready) begin
      va_seen  <= req_va;
      acc_seen <= req_acc;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  p_pa_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]);
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_fault_va_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_va == va_seen);
  p_mark_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[BIT_D] && mem_wdata[BIT_V] && mem_wdata[BIT_W]));
  p_store_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> acc_seen == ACC_STORE);
  p_one_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind ptw_top ptw_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_acc(req_acc), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_va(rsp_va),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_fault, rsp_kind;
  logic [31:0] rsp_pa, rsp_va;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ptw_top u0 (.*);

  // memory model: 16 KB, two-cycle latency
  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:15];
  int          nacc, nwr;
  logic        lat;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat     <= 1'b0;
      nacc    <= 0;
      nwr     <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lat) begin
          lat       <= 1'b0;
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[13:2]];
          log_addr[nacc[3:0]] <= mem_addr;
          nacc <= nacc + 1;
          if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            nwr <= nwr + 1;
          end
        end else begin
          lat <= 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] tbl_a(input int t);
    logic [3:0] tb = 4'(t);
    return ((32'h40000 + 32'(t)) << 12) | {28'd0, tb[2:0], ~tb[3]};
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // one walk; returns result and access/write counts
  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      output logic flt, output logic kind, output logic [31:0] pa,
                      output logic [31:0] rva, output int na, output int nw, output int a0);
    int n0, w0, guard;
    @(negedge clk);
    n0 = nacc; w0 = nwr; a0 = n0;
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", 64'(req_ready), 64'd0);
    guard = 0;
    while (!rsp_valid && guard < 60) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid == 1'b1, "R10 walk completes", 64'(rsp_valid), 64'd1);
    flt = rsp_fault; kind = rsp_kind; pa = rsp_pa; rva = rsp_va;
    na = nacc - n0; nw = nwr - w0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 ready after pulse",
        {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=<100000", cyc);
    finish_run();
  end

  initial begin
    logic flt, kind;
    logic [31:0] pa, rva, va, ent;
    int na, nw, a0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[1] = 32'h0000_1001;              // space A: dir 1 -> table 0x1000
    mem[3] = 32'h0000_1001;              // dir 3 aliases the same table
    for (int t = 0; t < 16; t++) mem[1024 + t] = tbl_a(t);
    mem[2048 + 1] = 32'h0000_3001;       // space B: dir 1 -> table 0x3000
    for (int t = 0; t < 16; t++) mem[3072 + t] = ((32'h50000 + 32'(t)) << 12) | 32'hF;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk(mem_req == 1'b0, "R1 memory idle after reset", 64'(mem_req), 64'd0);

    // full sweep: every entry pattern with every access code
    for (int t = 0; t < 16; t++) begin
      for (int a = 0; a < 4; a++) begin
        logic [3:0] tb;
        logic ok_perm, exp_v;
        logic [11:0] off;
        tb = 4'(t);
        off = 12'(t * 12'h137 + a * 3);
        va = {10'd1, 10'(t), off};
        exp_v = ~tb[3];
        ok_perm = (a == 0) ? tb[0] : (a == 1) ? tb[1] : (a == 2) ? tb[2] : 1'b0;
        walk(va, 2'(a), flt, kind, pa, rva, na, nw, a0);
        chk(rva == va, "R7 fault/result va", 64'(rva), 64'(va));
        chk(log_addr[a0[3:0]] == 32'h4, "R3 directory address", 64'(log_addr[a0[3:0]]), 64'h4);
        chk(log_addr[4'(a0 + 1)] == 32'h1000 + 32'(4 * t), "R3 table address",
            64'(log_addr[4'(a0 + 1)]), 64'(32'h1000 + 32'(4 * t)));
        if (!exp_v) begin
          chk(flt && kind == 1'b0, "R5 not-present fault", {flt, kind}, 2'b10);
          chk(na == 2, "R5 two accesses", 64'(na), 64'd2);
          chk(nw == 0, "R11 no write on fault", 64'(nw), 64'd0);
        end else if (!ok_perm) begin
          chk(flt && kind == 1'b1, "R6 permission fault", {flt, kind}, 2'b11);
          chk(nw == 0, "R11 no write on fault", 64'(nw), 64'd0);
        end else begin
          chk(!flt, "R6 permitted access", 64'(flt), 64'd0);
          chk(pa == {20'h40000 + 20'(t), off}, "R2 physical address",
              64'(pa), 64'({20'h40000 + 20'(t), off}));
          if (a == 1) begin
            ent = mem[1024 + t];
            chk(na == 3 && nw == 1, "R8 dirty write-back", {32'(na), 32'(nw)}, {32'd3, 32'd1});
            chk(ent == (tbl_a(t) | 32'h10), "R8 entry marked dirty", 64'(ent), 64'(tbl_a(t) | 32'h10));
          end else begin
            chk(nw == 0, "R11 no write on load/fetch", 64'(nw), 64'd0);
          end
        end
      end
    end

    // store to a page already dirty: no second write
    walk({10'd1, 10'd2, 12'h0AB}, 2'd1, flt, kind, pa, rva, na, nw, a0);
    chk(!flt && na == 2 && nw == 0, "R8 no rewrite when dirty",
        {31'd0, flt, 16'(na), 16'(nw)}, {32'd0, 16'd2, 16'd0});

    // invalid directory slots end after one access
    for (int d = 0; d < 3; d += 2) begin
      va = {10'(d), 10'd5, 12'h321};
      walk(va, 2'd0, flt, kind, pa, rva, na, nw, a0);
      chk(flt && kind == 1'b0, "R4 directory not present", {flt, kind}, 2'b10);
      chk(na == 1, "R4 single access", 64'(na), 64'd1);
      chk(rva == va, "R7 fault va", 64'(rva), 64'(va));
    end

    // aliased directory slot reaches the same table
    walk({10'd3, 10'd5, 12'h456}, 2'd2, flt, kind, pa, rva, na, nw, a0);
    chk(!flt && pa == 32'h4000_5456, "R3 alias directory slot", 64'(pa), 64'h4000_5456);

    // address space switch
    set_base(32'h0000_2000);
    walk({10'd1, 10'd9, 12'hFED}, 2'd1, flt, kind, pa, rva, na, nw, a0);
    chk(!flt && pa == 32'h5000_9FED, "R9 new space used", 64'(pa), 64'h5000_9FED);
    chk(log_addr[a0[3:0]] == 32'h2004, "R9 directory at new base", 64'(log_addr[a0[3:0]]), 64'h2004);
    walk({10'd3, 10'd9, 12'h001}, 2'd0, flt, kind, pa, rva, na, nw, a0);
    chk(flt && kind == 1'b0 && na == 1, "R9 slot absent in new space", {flt, kind}, 2'b10);
    set_base(32'h0000_0000);
    walk({10'd1, 10'd5, 12'h010}, 2'd0, flt, kind, pa, rva, na, nw, a0);
    chk(!flt && pa == 32'h4000_5010, "R9 switch back", 64'(pa), 64'h4000_5010);

    finish_run();
  end
endmodule